// File: doc/BRIEF.md
# Two-Bank Twister Uniform Word Source

This block generates a stream of 32-bit uniformly distributed words using the standard 32-bit twisted generalised feedback shift register with its 624-word state, degree 397, its twist constant and its output tempering. It is meant to sit in front of a stage that turns pairs of uniform words into pairs of Gaussian samples for a Monte Carlo pricing engine. For that reason it delivers its words two at a time: every second cycle a pair appears, together with a one-cycle valid pulse. No output handshake exists. The consumer must accept every pair.

The state is held in two half-depth memories. Words at even positions live in one of them and words at odd positions in the other. One iteration updates one even word and the odd word after it. Spread over its two cycles, that iteration needs exactly two reads and one write in each memory. A single read port and a single write port per memory are therefore enough to sustain one word per clock on average. Every index that walks around the state ring is advanced with an add, a compare against the ring size, and a conditional subtract. No divider or modulo operator is used.

After reset the block seeds itself from a parameter value. At any later time a pulse on the load input restarts seeding from the supplied value. Seeding fills the whole state one word per cycle before the first pair is produced.

Top module: `mt_dual_bank_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `valid_o` is low. After reset the block seeds itself from the parameter `DEFAULT_SEED` (5489 by default) with no further input.
- R2: Once seeding starts, `valid_o` stays low for at least 624 cycles while all 624 state words are written. The first pair then follows within 26 further cycles.
- R3: Each valid pair carries two consecutive outputs of the standard 32-bit twister sequence for the active seed. `rnd0_o` holds the earlier word and `rnd1_o` the later one, and no word is skipped or repeated between pairs.
- R4: With seed 5489, the first pair is `rnd0_o` = 0xD091BB5C and `rnd1_o` = 0x22AE9EF6.
- R5: Once the stream has started, `valid_o` is high in exactly every second cycle and is never high in two cycles in a row.
- R6: A cycle with `seed_load_i` high forces `valid_o` low in the next cycle and restarts seeding from `seed_i`. This also applies in the middle of an earlier seeding. The stream that follows is the sequence for the new seed, starting at its first word.
- R7: The sequence stays correct across the point where the whole state is regenerated, that is, from the 313th pair onward.
- R8: In any cycle with `valid_o` low, `rnd0_o` and `rnd1_o` keep the values they had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| seed_load_i | input | 1 | One-cycle request to reseed from `seed_i` |
| seed_i | input | 32 | Seed value taken when `seed_load_i` is high |
| rnd0_o | output | 32 | Earlier tempered word of the pair |
| rnd1_o | output | 32 | Later tempered word of the pair |
| valid_o | output | 1 | High for one cycle when a new pair is presented |

## Verification
The bench holds a plain array-based software model of the generator that uses ordinary modulo indexing. Every pair is compared against it under the default seed, under an arbitrary 32-bit seed, and under seed zero, which is reloaded while an earlier seeding is still running. The default seed pins the first pair to known constants, which separates a wrong tempering or twist from a wrong pairing order. Runs longer than 312 pairs show whether the compare-and-subtract index wrap and the second pass over the banks pick up the already-updated words. The reloads show whether pending results are flushed and seeding restarts cleanly. The check on every cycle of valid spacing and output hold tells a correct two-cycle cadence apart from dropped or doubled pairs.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef logic [31:0] word_t;

  localparam word_t TWIST_XOR   = 32'h9908B0DF;
  localparam word_t HI_MASK     = 32'h80000000;
  localparam word_t LO_MASK     = 32'h7FFFFFFF;
  localparam word_t TEMPER_MB   = 32'h9D2C5680;
  localparam word_t TEMPER_MC   = 32'hEFC60000;
  localparam word_t SEED_MULT   = 32'd1812433253;
  localparam int    SEED_SHIFT  = 30;
  localparam int    TEMPER_U    = 11;
  localparam int    TEMPER_S    = 7;
  localparam int    TEMPER_T    = 15;
  localparam int    TEMPER_L    = 18;

  // New state word: far word xor twisted mix of the upper bit of `hi`
  // and the lower bits of `lo`.
  function automatic word_t twist_word(input word_t hi, input word_t lo, input word_t far);
    word_t y;
    y = (hi & HI_MASK) | (lo & LO_MASK);
    return far ^ (y >> 1) ^ (y[0] ? TWIST_XOR : 32'h0);
  endfunction

  function automatic word_t temper_word(input word_t x);
    word_t y;
    y = x ^ (x >> TEMPER_U);
    y = y ^ ((y << TEMPER_S) & TEMPER_MB);
    y = y ^ ((y << TEMPER_T) & TEMPER_MC);
    y = y ^ (y >> TEMPER_L);
    return y;
  endfunction

  function automatic word_t seed_step(input word_t prev, input word_t pos);
    return word_t'(SEED_MULT * (prev ^ (prev >> SEED_SHIFT))) + pos;
  endfunction
endpackage

// File: rtl/mt_bank.sv
module mt_bank
  import mt_pkg::*;
#(
  parameter int DEPTH = 312,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  word_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R3: writes never leave the half-depth bank
  assert_bank_waddr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |-> (int'(waddr_i) < DEPTH));
endmodule

// File: rtl/mt_seeder.sv
module mt_seeder
  import mt_pkg::*;
#(
  parameter int    N_WORDS  = 624,
  parameter word_t SEED_DEF = 32'd5489,
  parameter int    IW       = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  word_t         seed_i,
  output logic          busy_o,
  output logic [IW-1:0] widx_o,
  output word_t         wdata_o
);
  localparam logic [IW-1:0] LAST = IW'(N_WORDS - 1);

  word_t         x_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b1;
      x_q    <= SEED_DEF;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      x_q    <= seed_i;
      idx_q  <= '0;
    end else if (busy_q) begin
      x_q   <= seed_step(x_q, word_t'(idx_q) + 32'd1);
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign widx_o  = idx_q;
  assign wdata_o = x_q;

  // R2: seeding index stays inside the state
  assert_seed_index_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |-> (int'(idx_q) < N_WORDS));
  // R2: seeding ends right after the last word unless restarted
  assert_seed_end_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && idx_q == LAST && !start_i) |=> !busy_q);
endmodule

// File: rtl/mt_temper_out.sv
module mt_temper_out
  import mt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  en_i,
  input  word_t raw0_i,
  input  word_t raw1_i,
  output word_t rnd0_o,
  output word_t rnd1_o,
  output logic  valid_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rnd0_o  <= '0;
      rnd1_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        rnd0_o <= temper_word(raw0_i);
        rnd1_o <= temper_word(raw1_i);
      end
    end
  end

  // R5: a pair never follows a pair in the next cycle
  assert_valid_spacing_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);
  // R8: outputs hold while no pair is presented
  assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ($stable(rnd0_o) && $stable(rnd1_o)));
endmodule

// File: rtl/mt_dual_bank_gen.sv
module mt_dual_bank_gen
  import mt_pkg::*;
#(
  parameter int          N_WORDS      = 624,
  parameter int          SHIFT_M      = 397,
  parameter logic [31:0] DEFAULT_SEED = 32'd5489
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        seed_load_i,
  input  logic [31:0] seed_i,
  output logic [31:0] rnd0_o,
  output logic [31:0] rnd1_o,
  output logic        valid_o
);
  localparam int HALF = N_WORDS / 2;
  localparam int IW   = $clog2(N_WORDS);
  localparam int HW   = IW - 1;
  // SHIFT_M is odd: word i+m of an even i is odd (bank 1), i+1+m is even (bank 0)
  localparam int OFF_ODD  = (SHIFT_M - 1) / 2;
  localparam int OFF_EVEN = (SHIFT_M + 1) / 2;

  function automatic logic [HW-1:0] ring_step(input logic [HW-1:0] x);
    logic [HW:0] s;
    s = {1'b0, x} + 1'b1;
    if (s >= (HW+1)'(HALF)) s = s - (HW+1)'(HALF);
    return s[HW-1:0];
  endfunction

  // seeding
  logic          seed_busy;
  logic [IW-1:0] seed_widx;
  word_t         seed_wdata;

  mt_seeder #(
    .N_WORDS (N_WORDS),
    .SEED_DEF(DEFAULT_SEED),
    .IW      (IW)
  ) seeder_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(seed_load_i),
    .seed_i (seed_i),
    .busy_o (seed_busy),
    .widx_o (seed_widx),
    .wdata_o(seed_wdata)
  );

  // generation control
  logic          gen_run;
  logic          ph_q;      // 0: first read cycle (also completes previous), 1: second
  logic          pend_q;    // an iteration awaits completion
  logic [HW-1:0] h_q, nxt_ptr_q, m_odd_q, m_even_q, wh_q;
  word_t         cur_q, y1_q, y2_q;
  logic          finish;
  word_t         new_even, new_odd;

  logic          b_we    [2];
  logic [HW-1:0] b_waddr [2];
  logic [HW-1:0] b_raddr [2];
  word_t         b_wdata [2];
  word_t         b_rdata [2];

  assign gen_run  = !seed_busy && !seed_load_i;
  assign finish   = gen_run && !ph_q && pend_q;
  assign new_even = twist_word(cur_q, y1_q, b_rdata[1]);
  assign new_odd  = twist_word(y1_q, y2_q, b_rdata[0]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q      <= 1'b0;
      pend_q    <= 1'b0;
      h_q       <= '0;
      nxt_ptr_q <= HW'(1);
      m_odd_q   <= HW'(OFF_ODD);
      m_even_q  <= HW'(OFF_EVEN);
      wh_q      <= '0;
      cur_q     <= '0;
      y1_q      <= '0;
      y2_q      <= '0;
    end else if (!gen_run) begin
      ph_q      <= 1'b0;
      pend_q    <= 1'b0;
      h_q       <= '0;
      nxt_ptr_q <= HW'(1);
      m_odd_q   <= HW'(OFF_ODD);
      m_even_q  <= HW'(OFF_EVEN);
      if (seed_busy && seed_widx == '0) cur_q <= seed_wdata;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        y1_q      <= b_rdata[1];
        y2_q      <= b_rdata[0];
        pend_q    <= 1'b1;
        wh_q      <= h_q;
        h_q       <= ring_step(h_q);
        nxt_ptr_q <= ring_step(nxt_ptr_q);
        m_odd_q   <= ring_step(m_odd_q);
        m_even_q  <= ring_step(m_even_q);
      end else if (pend_q) begin
        cur_q <= y2_q;
      end
    end
  end

  // banks: even state positions in bank 0, odd positions in bank 1
  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign b_we[g]    = (seed_busy && seed_widx[0] == 1'(g)) || finish;
    assign b_waddr[g] = seed_busy ? seed_widx[IW-1:1] : wh_q;
    assign b_wdata[g] = seed_busy ? seed_wdata : ((g == 0) ? new_even : new_odd);
    if (g == 0) begin : g_even
      assign b_raddr[g] = ph_q ? m_even_q : nxt_ptr_q;
    end else begin : g_odd
      assign b_raddr[g] = ph_q ? m_odd_q : h_q;
    end

    mt_bank #(
      .DEPTH(HALF),
      .AW   (HW)
    ) bank_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .we_i   (b_we[g]),
      .waddr_i(b_waddr[g]),
      .wdata_i(b_wdata[g]),
      .raddr_i(b_raddr[g]),
      .rdata_o(b_rdata[g])
    );
  end

  mt_temper_out out_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (finish),
    .raw0_i (new_even),
    .raw1_i (new_odd),
    .rnd0_o (rnd0_o),
    .rnd1_o (rnd1_o),
    .valid_o(valid_o)
  );

  // R2: no pair while the state is being seeded
  assert_quiet_seed_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    seed_busy |-> !valid_o);
  // R6: a reload drops the stream in the next cycle
  assert_load_drop_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    seed_load_i |=> !valid_o);
  // R3: a completion writes both banks at the same pair address
  assert_pair_write_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    finish |-> (b_we[0] && b_we[1] && b_waddr[0] == b_waddr[1]));
endmodule

// File: tb/mt_dual_bank_gen_tb_top.sv
module mt_dual_bank_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        seed_load;
  logic [31:0] seed;
  logic [31:0] rnd0, rnd1;
  logic        valid;

  always #10 clk = ~clk;

  mt_dual_bank_gen dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .seed_load_i(seed_load),
    .seed_i     (seed),
    .rnd0_o     (rnd0),
    .rnd1_o     (rnd1),
    .valid_o    (valid)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference: plain array, modulo indexing
  int unsigned ref_mt [624];
  int          ref_idx;
  int unsigned ref_seed_val;

  task automatic ref_seed(input int unsigned s);
    ref_seed_val = s;
    ref_mt[0] = s;
    for (int i = 1; i < 624; i++)
      ref_mt[i] = 32'd1812433253 * (ref_mt[i-1] ^ (ref_mt[i-1] >> 30)) + i;
    ref_idx = 624;
  endtask

  task automatic ref_next(output int unsigned r);
    int unsigned y;
    if (ref_idx >= 624) begin
      for (int k = 0; k < 624; k++) begin
        y = (ref_mt[k] & 32'h80000000) | (ref_mt[(k+1) % 624] & 32'h7FFFFFFF);
        ref_mt[k] = ref_mt[(k+397) % 624] ^ (y >> 1) ^ (((y & 1) != 0) ? 32'h9908B0DF : 0);
      end
      ref_idx = 0;
    end
    y = ref_mt[ref_idx];
    ref_idx++;
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & 32'h9D2C5680);
    y = y ^ ((y << 15) & 32'hEFC60000);
    y = y ^ (y >> 18);
    r = y;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor state
  bit          mon_on = 0;
  bit          streaming = 0;
  bit          first_seen = 0;
  int          since = 0;
  int          pairs = 0;
  logic        prev_valid = 0;
  logic [31:0] prev0 = 0, prev1 = 0;

  always @(negedge clk) begin
    int unsigned e0, e1;
    string tag;
    if (mon_on && !finished) begin
      since++;
      check(!(valid && prev_valid), "R5", "valid in consecutive cycles", {31'b0, valid}, 32'd0);
      if (streaming)
        check(valid || prev_valid, "R5", "gap of two cycles without a pair", {31'b0, valid}, 32'd1);
      if (!valid) begin
        check(rnd0 == prev0, "R8", "rnd0 changed while idle", rnd0, prev0);
        check(rnd1 == prev1, "R8", "rnd1 changed while idle", rnd1, prev1);
      end
      if (valid) begin
        check(since >= 624, "R2", "pair before seeding could finish", since, 624);
        ref_next(e0);
        ref_next(e1);
        tag = (pairs >= 312) ? "R7" : "R3";
        check(rnd0 == e0, tag, "rnd0 vs reference", rnd0, e0);
        check(rnd1 == e1, tag, "rnd1 vs reference", rnd1, e1);
        if (pairs == 0 && ref_seed_val == 32'd5489) begin
          check(rnd0 == 32'hD091BB5C, "R4", "first word, seed 5489", rnd0, 32'hD091BB5C);
          check(rnd1 == 32'h22AE9EF6, "R4", "second word, seed 5489", rnd1, 32'h22AE9EF6);
        end
        pairs++;
        streaming = 1;
        first_seen = 1;
      end else if (!first_seen && since == 650) begin
        check(1'b0, "R2", "no pair 650 cycles after seeding start", since, 650);
        first_seen = 1;
      end
      prev_valid = valid;
      prev0 = rnd0;
      prev1 = rnd1;
    end
  end

  task automatic reload(input logic [31:0] s);
    @(posedge clk); #1;
    seed_load = 1'b1;
    seed = s;
    @(posedge clk); #1;
    seed_load = 1'b0;
    ref_seed(s);
    pairs = 0;
    streaming = 0;
    first_seen = 0;
    since = 0;
    @(negedge clk);
    // R6: valid low in the cycle after the load request
    check(valid == 1'b0, "R6", "valid after reload", {31'b0, valid}, 32'd0);
  endtask

  task automatic wait_pairs(input int n);
    while (pairs < n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    seed_load = 1'b0;
    seed = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(valid == 1'b0, "R1", "valid during reset", {31'b0, valid}, 32'd0);
      check(rnd0 == 32'd0 && rnd1 == 32'd0, "R1", "outputs during reset", rnd0, 32'd0);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    ref_seed(32'd5489);
    since = 0;
    mon_on = 1;
    @(negedge clk);
    check(valid == 1'b0, "R1", "valid after reset release", {31'b0, valid}, 32'd0);
    wait_pairs(330);                 // crosses the state regeneration (R7)
    reload(32'h12345678);            // R6 new seed mid-stream
    wait_pairs(20);
    reload(32'hCAFEF00D);
    repeat (100) @(negedge clk);     // R6 restart in the middle of seeding
    reload(32'h00000000);
    wait_pairs(320);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule